// File: doc/BRIEF.md
# ATM Header HEC Generator

This block sits in the transmit path of an ATM transmission convergence stage. Cells arrive from the ATM layer as a stream of 53 bytes. A valid strobe qualifies each byte, and a start-of-cell flag marks the first byte of every cell. Over the first four header octets the block computes the header error control byte, which is a CRC-8. It writes that byte into the fifth octet and forwards every byte to the line side after one register stage.

Two configuration inputs control octet 5, and they act independently. One input suppresses the calculation. When it is set, octet 5 from the ATM layer goes out untouched. The other input XORs the fixed coset 0x55 into the computed value, so that an all-zero header does not produce an all-zero HEC. Both inputs are captured on the start-of-cell byte, so every cell is handled with a single consistent setting.

Top module: `atm_hec_gen`

## Requirements
- R1: With calculation enabled and the coset off, output byte index 4 equals the CRC-8 of byte indices 0 to 3. The CRC uses generator 0x07 (x^8+x^2+x+1), initial value 0x00, bits taken MSB first. Example: header 00 00 00 01 gives 0x07.
- R2: With the coset on, the computed value is XORed with 0x55. An all-zero header then gives 0x55, and with the coset off it gives 0x00.
- R3: While cfg_hec_off is 1, output byte index 4 equals the input byte 4, whatever cfg_coset_on holds.
- R4: Every byte other than index 4 leaves unchanged. This includes header bytes 0 to 3, payload bytes 5 to 52, and any byte arriving after index 52 with no new start-of-cell.
- R5: cfg_hec_off and cfg_coset_on are sampled on the start-of-cell byte. Changes later in the cell have no effect until the next start-of-cell.
- R6: out_valid, out_soc and out_data follow the accepted input byte exactly one clock later. Idle cycles between bytes are allowed and do not advance the byte count.
- R7: During reset, out_valid, out_soc and out_data are all 0.
- R8: A start-of-cell flag always restarts the byte count at index 0, even in the middle of a cell. The following cell is then processed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte qualifier |
| in_soc | input | 1 | Start-of-cell flag, meaningful with in_valid |
| in_data | input | 8 | Input byte from the ATM layer |
| cfg_hec_off | input | 1 | 1 = pass octet 5 unchanged |
| cfg_coset_on | input | 1 | 1 = XOR 0x55 into the computed HEC |
| out_valid | output | 1 | Output byte qualifier |
| out_soc | output | 1 | Start-of-cell flag of the output byte |
| out_data | output | 8 | Output byte to the line side |

## Verification
The assertions assume that in_soc has meaning only while in_valid is high. They also assume that the configuration inputs are stable on each start-of-cell byte.

The bench drives all inputs on the falling edge, so every sample is clean. It raises in_soc only together with in_valid. It changes configuration in the middle of a cell only in the scenario written for R5, and it never changes it on the start byte. Idle gaps and truncated cells are inserted on purpose, so the index-based pass-through properties are exercised away from the simple back-to-back case.

// File: rtl/atm_hec_gen.sv
module atm_hec_gen #(
  parameter int         CELL_LEN = 53,
  parameter int         HDR_LEN  = 4,
  parameter logic [7:0] COSET    = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_soc,
  input  logic [7:0] in_data,
  input  logic       cfg_hec_off,
  input  logic       cfg_coset_on,
  output logic       out_valid,
  output logic       out_soc,
  output logic [7:0] out_data
);
  localparam int IW = $clog2(CELL_LEN + 1);
  localparam logic [IW-1:0] IDX_END = IW'(CELL_LEN);
  localparam logic [IW-1:0] IDX_HEC = IW'(HDR_LEN);

  logic [IW-1:0] nxt_idx;
  logic [IW-1:0] cur_idx;
  logic [7:0]    crc_q;
  logic          off_q, coset_q;

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[6:0], 1'b0} ^ ((r[7] ^ d[i]) ? 8'h07 : 8'h00);
    return r;
  endfunction

  assign cur_idx = in_soc ? '0 : nxt_idx;
  wire is_hec = (cur_idx == IDX_HEC);
  wire is_hdr = (cur_idx < IDX_HEC);
  wire [7:0] hec_val = crc_q ^ (coset_q ? COSET : 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_idx   <= IDX_END;
      crc_q     <= '0;
      off_q     <= 1'b0;
      coset_q   <= 1'b0;
      out_valid <= 1'b0;
      out_soc   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_soc   <= in_valid & in_soc;
      if (in_valid) begin
        nxt_idx  <= (cur_idx == IDX_END) ? IDX_END : cur_idx + 1'b1;
        out_data <= (is_hec && !off_q) ? hec_val : in_data;
        if (in_soc) begin
          off_q   <= cfg_hec_off;
          coset_q <= cfg_coset_on;
        end
        if (is_hdr)
          crc_q <= crc8_step(in_soc ? 8'h00 : crc_q, in_data);
      end
    end
  end

  p_lat_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));
  p_lat_soc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_soc) |=> out_soc);
  p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_hec) |=> (out_data == $past(in_data)));
  p_off_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_hec && off_q) |=> (out_data == $past(in_data)));
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_soc) |=> ($stable(off_q) && $stable(coset_q)));
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_soc) |=> (nxt_idx == IW'(1)));
endmodule

// File: tb/atm_hec_gen_bench.sv
module atm_hec_gen_bench;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_soc = 0;
  logic [7:0] in_data = 0;
  logic cfg_hec_off = 0, cfg_coset_on = 0;
  logic out_valid, out_soc;
  logic [7:0] out_data;
  int checks = 0, errors = 0;
  logic [7:0] cap [0:127];
  logic       cap_soc [0:127];
  int ncap = 0;

  atm_hec_gen u_atm_hec_gen (.*);

  always #10 clk = ~clk;

  always @(negedge clk)
    if (rst_n && out_valid && ncap < 128) begin
      cap[ncap] = out_data; cap_soc[ncap] = out_soc; ncap++;
    end

  function automatic logic [7:0] ref_crc(input logic [31:0] h);
    logic [7:0] c = 0;
    for (int i = 31; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ h[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int i, input int seed);
    return 8'(i * 7 + seed);
  endfunction

  task automatic put(input logic s, input logic [7:0] d);
    @(negedge clk); in_valid = 1; in_soc = s; in_data = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); in_valid = 0; in_soc = 0;
    end
  endtask

  task automatic send_cell(input logic [31:0] h, input logic [7:0] hin, input int seed,
                           input int gap, input int len);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = (i < 4) ? h[31-8*i -: 8] : (i == 4) ? hin : pay(i, seed);
      put(i == 0, b);
      if (gap > 0 && i % 5 == 2) idle(gap);
    end
    idle(3);
  endtask

  task automatic check_cell(input string req, input int base, input logic [31:0] h,
                            input logic [7:0] hexp, input int seed);
    chk({req, " soc"}, cap_soc[base], 1'b1);
    chk({req, " hec byte"}, cap[base+4], hexp);
    for (int i = 0; i < 53; i++) begin
      logic [7:0] e;
      if (i == 4) continue;
      e = (i < 4) ? h[31-8*i -: 8] : pay(i, seed);
      if (cap[base+i] !== e) begin
        chk("R4 byte pass", cap[base+i], e); return;
      end
    end
    chk("R4 all bytes pass", 1, 1);
  endtask

  task automatic t_reset;
    chk("R7 out_valid", out_valid, 0);
    chk("R7 out_soc", out_soc, 0);
    chk("R7 out_data", out_data, 0);
  endtask

  task automatic t_calc;
    logic [31:0] h = 32'h0000_0001;
    chk("R1 ref crc", ref_crc(h), 8'h07);
    ncap = 0; cfg_hec_off = 0; cfg_coset_on = 0;
    send_cell(h, 8'hEE, 3, 0, 53);
    check_cell("R1", 0, h, 8'h07, 3);
    h = 32'h1234_5678; ncap = 0;
    send_cell(h, 8'h00, 9, 2, 53);
    check_cell("R1 gaps", 0, h, ref_crc(h), 9);
  endtask

  task automatic t_coset;
    logic [31:0] h = 32'hA0B1_C2D3;
    ncap = 0; cfg_hec_off = 0; cfg_coset_on = 1;
    send_cell(32'h0, 8'h00, 5, 0, 53);
    check_cell("R2 zero hdr coset", 0, 32'h0, 8'h55, 5);
    ncap = 0; cfg_coset_on = 0;
    send_cell(32'h0, 8'hAA, 5, 0, 53);
    check_cell("R2 zero hdr plain", 0, 32'h0, 8'h00, 5);
    ncap = 0; cfg_coset_on = 1;
    send_cell(h, 8'h00, 1, 0, 53);
    check_cell("R2 coset", 0, h, ref_crc(h) ^ 8'h55, 1);
    chk("R2 known", ref_crc(32'h0000_0001) ^ 8'h55, 8'h52);
  endtask

  task automatic t_off;
    ncap = 0; cfg_hec_off = 1; cfg_coset_on = 1;
    send_cell(32'hDEAD_BEEF, 8'h3C, 2, 0, 53);
    check_cell("R3 off coset", 0, 32'hDEAD_BEEF, 8'h3C, 2);
    ncap = 0; cfg_coset_on = 0;
    send_cell(32'h0, 8'hC3, 2, 1, 53);
    check_cell("R3 off plain", 0, 32'h0, 8'hC3, 2);
    cfg_hec_off = 0;
  endtask

  task automatic t_midcell_cfg;
    logic [31:0] h = 32'h0102_0304;
    ncap = 0; cfg_hec_off = 0; cfg_coset_on = 1;
    for (int i = 0; i < 53; i++) begin
      put(i == 0, (i < 4) ? h[31-8*i -: 8] : (i == 4) ? 8'h99 : pay(i, 4));
      if (i == 1) begin cfg_hec_off = 1; cfg_coset_on = 0; end
    end
    idle(3);
    check_cell("R5 mid-cell change ignored", 0, h, ref_crc(h) ^ 8'h55, 4);
    ncap = 0;
    send_cell(h, 8'h99, 4, 0, 53);
    check_cell("R5 new setting next cell", 0, h, 8'h99, 4);
    cfg_hec_off = 0;
  endtask

  task automatic t_latency;
    ncap = 0;
    put(1, 8'h5A); idle(0);
    @(negedge clk); in_valid = 0; in_soc = 0;
    chk("R6 out_valid next cycle", out_valid, 1);
    chk("R6 out_soc next cycle", out_soc, 1);
    chk("R6 out_data next cycle", out_data, 8'h5A);
    @(negedge clk);
    chk("R6 out_valid drops", out_valid, 0);
    idle(2);
  endtask

  task automatic t_restart;
    logic [31:0] h = 32'hFFFF_FFFF;
    ncap = 0; cfg_hec_off = 0; cfg_coset_on = 0;
    send_cell(32'h1111_1111, 8'h00, 6, 0, 3);
    send_cell(h, 8'h00, 7, 0, 53);
    check_cell("R8 restart", 3, h, ref_crc(h), 7);
    ncap = 0;
    send_cell(h, 8'h00, 7, 0, 53);
    for (int i = 0; i < 8; i++) put(0, 8'hF0 + 8'(i));
    idle(3);
    for (int i = 0; i < 8; i++) chk("R4 overrun pass", cap[53+i], 8'hF0 + 8'(i));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1;
        t_latency;
        t_calc;
        t_coset;
        t_off;
        t_midcell_cfg;
        t_restart;
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule